// File: doc/BRIEF.md
# Configuration Port Decoder for Internal I/O Space

This block sits on the path of accesses aimed at the internal I/O address space and decides, one request at a time, where each one goes. It keeps one 32-bit configuration-address register, which software writes and reads through a dedicated port. Accesses to a four-byte data window are steered to one of two places:

- configuration space, at an address built from the stored register, when the register's enable bit is set;
- plain I/O space otherwise.

Every other port number passes straight through as an I/O access.

Each request is decoded in one clock. The response registers the following outputs: a two-bit target select, a physical address, uncacheable and strictly-ordered flags, an error flag, and read data from the address register. The block does not carry the bus protocol, does not move data to the target, and does not model the devices behind configuration space.

Top module: `cfgio_port_decoder`

## Requirements
- R1: After reset the configuration-address register holds zero, and `resp_valid` is low until a request is taken.
- R2: A write to port 0xCF8 with size exactly 4 and no address bit set above bit 15 stores `req_wdata` in the register. Its response has target select 0, physical address 0, and both flags clear.
- R3: A read of port 0xCF8 with size 4 returns the register value on `resp_rdata`, with target select 0 and both flags clear. `resp_rdata` is zero for every other response.
- R4: An access to port 0xCF8 with any size other than 4 is an I/O access: target select 2, physical address 0x8000_0000_0000_0000 ORed with the port. The register is left unchanged.
- R5: For ports 0xCFC to 0xCFF with register bit 31 set, the target select is 1. The physical address is 0xC000_0000_0000_0000 ORed with register bits 30:2 at bits 30:2 and the port's low two bits at bits 1:0.
- R6: For ports 0xCFC to 0xCFF with register bit 31 clear, the target select is 2 and the physical address is the I/O prefix 0x8000_0000_0000_0000 ORed with the port.
- R7: Any other port in range gives target select 2, with the I/O prefix ORed with the port, and no change to the register.
- R8: The uncacheable and ordered flags are both set for target selects 1 and 2, and both clear otherwise.
- R9: A request whose address has any bit above bit 15 set raises `resp_err`, with target select 3, physical address 0 and flags clear. It never changes the register.
- R10: The response appears in the cycle after the request is taken. A cycle without a request gives `resp_valid` low and all response fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Internal I/O address; bits 15:0 are the port |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data for the address register |
| resp_valid | output | 1 | Response present |
| resp_tgt | output | 2 | 0 address register, 1 config space, 2 I/O, 3 none |
| resp_phys | output | 64 | Physical target address |
| resp_uncacheable | output | 1 | Access must bypass caches |
| resp_ordered | output | 1 | Access must be strictly ordered |
| resp_err | output | 1 | Port number out of range |
| resp_rdata | output | 32 | Address-register read data |

## Verification
A register update and a data-window decode can fall on the same clock edge. A write to 0xCF8 commits at the same edge that registers its response. If a window access follows in the very next cycle, it must already be steered by the new register value. The bench issues such back-to-back pairs, both with bit 31 set and with it clear, and a behavioural model that updates its own register copy in request order judges every response field on each clock.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
   typedef enum logic [1:0] {
      TGT_CADDR = 2'd0,
      TGT_CFG   = 2'd1,
      TGT_IO    = 2'd2,
      TGT_NONE  = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e tgt;
      logic err;
      logic unc;
      logic ord;
   } dec_s;
endpackage

// File: rtl/cfgio_port_class.sv
module cfgio_port_class #(
   parameter int          ADDR_W    = 32,
   parameter int          PORT_W    = 16,
   parameter int          SZ_W      = 4,
   parameter int          ADDR_SIZE = 4,
   parameter logic [15:0] ADDR_PORT = 16'hCF8,
   parameter logic [15:0] DATA_PORT = 16'hCFC
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   size,
   output logic [PORT_W-1:0] port,
   output logic              hi_err,
   output logic              hit_caddr,
   output logic              hit_window
);
   localparam logic [PORT_W-1:0] AP = PORT_W'(ADDR_PORT);
   localparam logic [PORT_W-1:0] DP = PORT_W'(DATA_PORT);

   assign port = addr[PORT_W-1:0];

   generate
      if (ADDR_W > PORT_W) begin : g_hi
         assign hi_err = |addr[ADDR_W-1:PORT_W];
      end else begin : g_nohi
         assign hi_err = 1'b0;
      end
   endgenerate

   always_comb begin
      hit_caddr  = !hi_err && (port == AP) && (size == SZ_W'(ADDR_SIZE));
      hit_window = !hi_err && (port[PORT_W-1:2] == DP[PORT_W-1:2]);
   end
endmodule

// File: rtl/cfgio_addr_reg.sv
module cfgio_addr_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/cfgio_target_build.sv
module cfgio_target_build
   import cfgio_pkg::*;
#(
   parameter int              PORT_W     = 16,
   parameter int              EN_BIT     = 31,
   parameter int              PA_W       = 64,
   parameter logic [PA_W-1:0] CFG_PREFIX = 64'hC000_0000_0000_0000,
   parameter logic [PA_W-1:0] IO_PREFIX  = 64'h8000_0000_0000_0000
) (
   input  logic [PORT_W-1:0]   port,
   input  logic [EN_BIT-3:0]   cfg_field,
   input  logic                cfg_en,
   input  logic                hi_err,
   input  logic                hit_caddr,
   input  logic                hit_window,
   output dec_s                dec,
   output logic [PA_W-1:0]     phys
);
   logic [PA_W-1:0] io_addr;
   logic [PA_W-1:0] cfg_addr;

   always_comb begin
      io_addr                = '0;
      io_addr[PORT_W-1:0]    = port;
      io_addr                = io_addr | IO_PREFIX;
      cfg_addr               = '0;
      cfg_addr[EN_BIT-1:0]   = {cfg_field, port[1:0]};
      cfg_addr               = cfg_addr | CFG_PREFIX;
   end

   always_comb begin
      dec  = '{tgt: TGT_IO, err: 1'b0, unc: 1'b1, ord: 1'b1};
      phys = io_addr;
      if (hi_err) begin
         dec  = '{tgt: TGT_NONE, err: 1'b1, unc: 1'b0, ord: 1'b0};
         phys = '0;
      end else if (hit_caddr) begin
         dec  = '{tgt: TGT_CADDR, err: 1'b0, unc: 1'b0, ord: 1'b0};
         phys = '0;
      end else if (hit_window && cfg_en) begin
         dec.tgt = TGT_CFG;
         phys    = cfg_addr;
      end
   end
endmodule

// File: rtl/cfgio_port_decoder.sv
module cfgio_port_decoder
   import cfgio_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              PORT_W     = 16,
   parameter int              DATA_W     = 32,
   parameter int              SZ_W       = 4,
   parameter int              PA_W       = 64,
   parameter int              EN_BIT     = 31,
   parameter int              ADDR_SIZE  = 4,
   parameter bit              REG_OUT    = 1'b1,
   parameter logic [15:0]     ADDR_PORT  = 16'hCF8,
   parameter logic [15:0]     DATA_PORT  = 16'hCFC,
   parameter logic [PA_W-1:0] CFG_PREFIX = 64'hC000_0000_0000_0000,
   parameter logic [PA_W-1:0] IO_PREFIX  = 64'h8000_0000_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SZ_W-1:0]   req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [1:0]        resp_tgt,
   output logic [PA_W-1:0]   resp_phys,
   output logic              resp_uncacheable,
   output logic              resp_ordered,
   output logic              resp_err,
   output logic [DATA_W-1:0] resp_rdata
);
   generate
      if (PORT_W < 3 || PORT_W > ADDR_W || PORT_W > 16) begin : g_bad_port
         $error("cfgio_port_decoder: PORT_W out of range");
      end
      if (EN_BIT < 3 || EN_BIT >= DATA_W) begin : g_bad_en
         $error("cfgio_port_decoder: EN_BIT must lie inside the register");
      end
      if (PA_W < EN_BIT || PA_W < PORT_W) begin : g_bad_pa
         $error("cfgio_port_decoder: PA_W too narrow");
      end
      if (ADDR_SIZE >= (1 << SZ_W)) begin : g_bad_sz
         $error("cfgio_port_decoder: ADDR_SIZE does not fit SZ_W");
      end
   endgenerate

   logic [PORT_W-1:0] port;
   logic              hi_err;
   logic              hit_caddr;
   logic              hit_window;
   logic [DATA_W-1:0] cfg_q;
   logic              cfg_we;
   dec_s              dec;
   logic [PA_W-1:0]   phys;

   cfgio_port_class #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SZ_W(SZ_W),
      .ADDR_SIZE(ADDR_SIZE), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
   ) u_class (
      .addr(req_addr), .size(req_size), .port(port),
      .hi_err(hi_err), .hit_caddr(hit_caddr), .hit_window(hit_window)
   );

   assign cfg_we = req_valid && req_write && hit_caddr;

   cfgio_addr_reg #(.DATA_W(DATA_W)) u_areg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(req_wdata), .q(cfg_q)
   );

   cfgio_target_build #(
      .PORT_W(PORT_W), .EN_BIT(EN_BIT), .PA_W(PA_W),
      .CFG_PREFIX(CFG_PREFIX), .IO_PREFIX(IO_PREFIX)
   ) u_build (
      .port(port), .cfg_field(cfg_q[EN_BIT-1:2]), .cfg_en(cfg_q[EN_BIT]),
      .hi_err(hi_err), .hit_caddr(hit_caddr), .hit_window(hit_window),
      .dec(dec), .phys(phys)
   );

   logic              n_valid;
   logic [1:0]        n_tgt;
   logic [PA_W-1:0]   n_phys;
   logic              n_unc;
   logic              n_ord;
   logic              n_err;
   logic [DATA_W-1:0] n_rdata;

   always_comb begin
      n_valid = req_valid;
      n_tgt   = req_valid ? dec.tgt : 2'd0;
      n_phys  = req_valid ? phys    : '0;
      n_unc   = req_valid && dec.unc;
      n_ord   = req_valid && dec.ord;
      n_err   = req_valid && dec.err;
      n_rdata = (req_valid && !req_write && hit_caddr) ? cfg_q : '0;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               resp_valid       <= 1'b0;
               resp_tgt         <= 2'd0;
               resp_phys        <= '0;
               resp_uncacheable <= 1'b0;
               resp_ordered     <= 1'b0;
               resp_err         <= 1'b0;
               resp_rdata       <= '0;
            end else begin
               resp_valid       <= n_valid;
               resp_tgt         <= n_tgt;
               resp_phys        <= n_phys;
               resp_uncacheable <= n_unc;
               resp_ordered     <= n_ord;
               resp_err         <= n_err;
               resp_rdata       <= n_rdata;
            end
         end
      end else begin : g_comb_out
         always_comb begin
            resp_valid       = n_valid;
            resp_tgt         = n_tgt;
            resp_phys        = n_phys;
            resp_uncacheable = n_unc;
            resp_ordered     = n_ord;
            resp_err         = n_err;
            resp_rdata       = n_rdata;
         end
      end
   endgenerate
endmodule

// File: rtl/cfgio_port_decoder_chk.sv
module cfgio_port_decoder_chk #(
   parameter int          ADDR_W    = 32,
   parameter int          PORT_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          SZ_W      = 4,
   parameter int          PA_W      = 64,
   parameter int          ADDR_SIZE = 4,
   parameter bit          REG_OUT   = 1'b1,
   parameter logic [15:0] ADDR_PORT = 16'hCF8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [SZ_W-1:0]   req_size,
   input logic [DATA_W-1:0] req_wdata,
   input logic              resp_valid,
   input logic [1:0]        resp_tgt,
   input logic [PA_W-1:0]   resp_phys,
   input logic              resp_uncacheable,
   input logic              resp_ordered,
   input logic              resp_err,
   input logic [DATA_W-1:0] cfg_q
);
   logic caddr_wr;
   assign caddr_wr = req_valid && req_write && (req_size == SZ_W'(ADDR_SIZE))
                     && (req_addr == ADDR_W'(ADDR_PORT));

   a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> cfg_q == '0);

   a_r2_reg_loads: assert property (@(posedge clk) disable iff (!rst_n)
      caddr_wr |=> cfg_q == $past(req_wdata));

   a_r4_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !caddr_wr |=> $stable(cfg_q));

   a_r8_flags_io_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && (resp_tgt == 2'd1 || resp_tgt == 2'd2))
         |-> (resp_uncacheable && resp_ordered));

   a_r8_flags_other: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_tgt == 2'd0 || resp_tgt == 2'd3) |-> !(resp_uncacheable || resp_ordered));

   a_r9_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> (resp_tgt == 2'd3 && resp_phys == '0 && resp_valid));

   generate
      if (REG_OUT) begin : g_lat
         a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> resp_valid);
         a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !resp_valid);
      end
   endgenerate
endmodule

bind cfgio_port_decoder cfgio_port_decoder_chk #(
   .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_W(DATA_W), .SZ_W(SZ_W),
   .PA_W(PA_W), .ADDR_SIZE(ADDR_SIZE), .REG_OUT(REG_OUT), .ADDR_PORT(ADDR_PORT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
   .resp_valid(resp_valid), .resp_tgt(resp_tgt), .resp_phys(resp_phys),
   .resp_uncacheable(resp_uncacheable), .resp_ordered(resp_ordered),
   .resp_err(resp_err), .cfg_q(cfg_q)
);

// File: tb/cfgio_port_decoder_test.sv
module cfgio_port_decoder_test;
   localparam logic [63:0] CFGP = 64'hC000_0000_0000_0000;
   localparam logic [63:0] IOP  = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        resp_valid;
   logic [1:0]  resp_tgt;
   logic [63:0] resp_phys;
   logic        resp_uncacheable;
   logic        resp_ordered;
   logic        resp_err;
   logic [31:0] resp_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   cfgio_port_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_tgt(resp_tgt), .resp_phys(resp_phys),
      .resp_uncacheable(resp_uncacheable), .resp_ordered(resp_ordered),
      .resp_err(resp_err), .resp_rdata(resp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // behavioural reference
   logic [31:0] m_cfg;
   logic        e_valid, e_unc, e_ord, e_err;
   logic [1:0]  e_tgt;
   logic [63:0] e_phys;
   logic [31:0] e_rdata;
   string       e_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = '0; e_valid = 0; e_tgt = 0; e_phys = 0; e_unc = 0;
         e_ord = 0; e_err = 0; e_rdata = 0; e_tag = "R1";
      end else begin
         e_valid = req_valid; e_tgt = 0; e_phys = 0; e_unc = 0;
         e_ord = 0; e_err = 0; e_rdata = 0;
         if (!req_valid) e_tag = "R10";
         else if (req_addr[31:16] != 0) begin
            e_err = 1; e_tgt = 3; e_tag = "R9";
         end else if (req_addr[15:0] == 16'hCF8 && req_size == 4) begin
            if (req_write) begin m_cfg = req_wdata; e_tag = "R2"; end
            else begin e_rdata = m_cfg; e_tag = "R3"; end
         end else begin
            e_unc = 1; e_ord = 1; e_tgt = 2;
            e_phys = IOP | {48'd0, req_addr[15:0]};
            if (req_addr[15:2] == 14'h33F) begin
               if (m_cfg[31]) begin
                  e_tgt = 1;
                  e_phys = CFGP | {33'd0, m_cfg[30:2], req_addr[1:0]};
                  e_tag = "R5";
               end else e_tag = "R6";
            end else if (req_addr[15:0] == 16'hCF8) e_tag = "R4";
            else e_tag = "R7";
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cycles > 1) begin
         chk(resp_valid == e_valid, e_tag, "valid", 64'(resp_valid), 64'(e_valid));
         chk(resp_tgt == e_tgt, e_tag, "tgt", 64'(resp_tgt), 64'(e_tgt));
         chk(resp_phys == e_phys, e_tag, "phys", resp_phys, e_phys);
         chk(resp_uncacheable == e_unc && resp_ordered == e_ord, "R8", "flags",
             {62'd0, resp_uncacheable, resp_ordered}, {62'd0, e_unc, e_ord});
         chk(resp_err == e_err, e_tag, "err", 64'(resp_err), 64'(e_err));
         chk(resp_rdata == e_rdata, e_tag, "rdata", 64'(resp_rdata), 64'(e_rdata));
      end
   end

   task automatic req(input bit wr, input logic [31:0] a, input logic [3:0] sz,
                      input logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(resp_valid == 0, "R1", "valid in reset", 64'(resp_valid), 0);
      @(negedge clk); rst_n = 1;
      idle();
      @(negedge clk);
      chk(resp_valid == 0, "R1", "valid after reset", 64'(resp_valid), 0);
      // R1: register reads back zero
      req(0, 32'hCF8, 4, 0);
      idle();
      chk(resp_rdata == 0 && resp_tgt == 0, "R1", "reset register", 64'(resp_rdata), 0);
      // back-to-back: write then window access (R2, R5)
      req(1, 32'hCF8, 4, 32'h8000_1237);
      req(0, 32'hCFD, 1, 0);
      idle();
      chk(resp_phys == 64'hC000_0000_0000_1235, "R5", "window phys",
          resp_phys, 64'hC000_0000_0000_1235);
      // R4: wrong size leaves register alone
      req(1, 32'hCF8, 2, 32'h0);
      req(0, 32'hCF8, 4, 0);
      idle();
      chk(resp_rdata == 32'h8000_1237, "R4", "reg kept", 64'(resp_rdata), 64'h8000_1237);
      // R6: enable clear, back-to-back
      req(1, 32'hCF8, 4, 32'h0000_ABCC);
      req(1, 32'hCFE, 2, 32'h55);
      req(0, 32'hCFF, 1, 0);
      // R7 and R9
      req(0, 32'h03F8, 1, 0);
      req(1, 32'h0001_0CF8, 4, 32'hFFFF_FFFF);
      req(0, 32'hCF8, 4, 0);
      idle();
      chk(resp_rdata == 32'h0000_ABCC, "R9", "reg untouched", 64'(resp_rdata), 64'hABCC);
      idle();
      // mixed sweep
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         int sel;
         sel = $urandom_range(0, 9);
         case (sel)
            0, 1: a = 32'hCF8;
            2, 3, 4: a = 32'hCFC | 32'($urandom_range(0, 3));
            5: a = 32'($urandom_range(0, 16'hFFFF));
            6: a = {16'($urandom_range(1, 3)), 16'hCFC};
            default: a = 32'hCF8 + 32'($urandom_range(0, 8));
         endcase
         if ($urandom_range(0, 4) == 0) idle();
         else req($urandom_range(0, 1) == 1, a, 4'($urandom_range(1, 4)), $urandom());
      end
      idle();
      idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule